// File: doc/BRIEF.md
# Lock Register Command-Mode Controller

This block sits between a simple command bus and the banks of a multi-bank flash array and guards the small protection register of that array. The register holds three one-time-programmable flags: a secure-sector lock, a persistent-protection selection and a password-protection selection. Ordinary reads and writes pass straight to the array. A dedicated entry command opens a lock mode. In that mode, lock-program and lock-read commands are accepted, and bank 0 is fenced off. Bank 0 is released when the exit command is given.

A program operation does not alter the stored flags at once. It marks bits as pending, and the pending bits are merged into the stored flags only by the exit command. A program that asks for both protection-mode selections together is dropped for those two bits. A flag that is already set can never be cleared. The stored flags are kept across reset, which models nonvolatile storage. The mode state and any pending bits are cleared by reset.

Commands come in as decoded opcodes on `cmd_op`. Responses are registered and appear one cycle after the command.

Top module: `lockreg_ctrl`

## Requirements
- R1: The opcodes are encoded as 0 idle, 1 array read, 2 array write, 3 enter lock mode, 4 lock program, 5 lock read and 6 exit. Opcodes 4, 5 and 6 have no effect while lock mode is inactive: no response, no error, and no change to `mode_busy` or `lock_bits`.
- R2: The enter command raises `mode_busy` on the next cycle. `mode_busy` then stays high until an exit command is accepted.
- R3: While `mode_busy` is high, a read or write to bank 0 is not forwarded (`arr_en` stays low). It raises `err_pulse` for exactly one cycle on the following cycle. A blocked read also returns a response whose data is all ones.
- R4: Reads and writes to any bank other than bank 0 are forwarded to the array in the same cycle, whether or not lock mode is active. A read returns `arr_rdata` one cycle later with `err_pulse` low.
- R5: The exit command clears `mode_busy` on the next cycle, after which bank 0 reads and writes are forwarded again.
- R6: A lock program leaves `lock_bits` unchanged. The requested bits take effect in `lock_bits` on the cycle after the exit command that follows. `cmd_wdata` bit 0 requests the secure-sector lock, bit 1 the persistent selection and bit 2 the password selection.
- R7: A single program that requests both bit 1 and bit 2 programs neither of them. A secure-sector request in the same program is still honoured.
- R8: A set bit of `lock_bits` never returns to 0. A program with a bit cleared leaves that bit as it was.
- R9: Inside lock mode, a lock read returns on the next cycle the stored flags in data bits 0 (secure), 1 (persistent) and 2 (password), with every other data bit set to 1.
- R10: Reset clears `mode_busy` and any pending bits, but keeps `lock_bits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Decoded opcode |
| cmd_bank | input | BANK_W | Bank field of the address |
| cmd_addr | input | ADDR_W | Offset within the bank |
| cmd_wdata | input | DATA_W | Write data or program mask |
| arr_en | output | 1 | Access forwarded to the array |
| arr_we | output | 1 | Forwarded access is a write |
| arr_bank | output | BANK_W | Forwarded bank |
| arr_addr | output | ADDR_W | Forwarded offset |
| arr_wdata | output | DATA_W | Forwarded write data |
| arr_rdata | input | DATA_W | Array read data, same cycle |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DATA_W | Read response data |
| err_pulse | output | 1 | One-cycle flag for a blocked access |
| mode_busy | output | 1 | Lock mode active (device held until exit) |
| lock_bits | output | 3 | Stored protection flags |

## Verification
On every cycle, the assertions check four things: that a bank 0 access inside lock mode is never forwarded and is always followed by an error pulse, that stored flags never fall, that stored flags change only after an accepted exit, and that a lock read outside the mode gives no response. The deferred commit needs the bench's scenarios to show it, and so do the drop of a combined mode-selection program, persistence across reset and the exact lock-read data. The bench sweeps every program mask against a model of the stored flags.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;
   localparam int unsigned NUM_LOCKS = 3;
   localparam int unsigned LK_SECURE = 0;
   localparam int unsigned LK_PERSIST = 1;
   localparam int unsigned LK_PASSWD = 2;

   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_RD    = 3'd1,
      OP_WR    = 3'd2,
      OP_ENTER = 3'd3,
      OP_PROG  = 3'd4,
      OP_LREAD = 3'd5,
      OP_EXIT  = 3'd6
   } op_e;
endpackage

// File: rtl/lockreg_decode.sv
module lockreg_decode
   import lockreg_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned GUARD_BANK = 0
) (
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic              mode_q,
   output logic              acc_fwd,
   output logic              acc_wr,
   output logic              rd_fwd,
   output logic              acc_block,
   output logic              rd_block,
   output logic              enter_go,
   output logic              prog_go,
   output logic              lread_go,
   output logic              exit_go
);
   localparam logic [BANK_W-1:0] GUARD = BANK_W'(GUARD_BANK);

   op_e  op;
   logic is_rd, is_wr, is_rw, guarded;

   assign op      = op_e'(cmd_op);
   assign is_rd   = cmd_valid && (op == OP_RD);
   assign is_wr   = cmd_valid && (op == OP_WR);
   assign is_rw   = is_rd || is_wr;
   assign guarded = mode_q && (cmd_bank == GUARD);

   assign acc_fwd   = is_rw && !guarded;
   assign acc_wr    = is_wr;
   assign rd_fwd    = is_rd && !guarded;
   assign acc_block = is_rw && guarded;
   assign rd_block  = is_rd && guarded;

   assign enter_go = cmd_valid && (op == OP_ENTER) && !mode_q;
   assign prog_go  = cmd_valid && (op == OP_PROG)  && mode_q;
   assign lread_go = cmd_valid && (op == OP_LREAD) && mode_q;
   assign exit_go  = cmd_valid && (op == OP_EXIT)  && mode_q;
endmodule

// File: rtl/lockreg_otp.sv
module lockreg_otp
   import lockreg_pkg::*;
#(
   parameter bit EXCLUSIVE_MODES = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prog_go,
   input  logic [NUM_LOCKS-1:0] prog_mask,
   input  logic                 exit_go,
   output logic [NUM_LOCKS-1:0] stored
);
   logic [NUM_LOCKS-1:0] req;

   generate
      if (EXCLUSIVE_MODES) begin : g_excl
         always_comb begin
            req = prog_mask;
            if (prog_mask[LK_PERSIST] && prog_mask[LK_PASSWD]) begin
               req[LK_PERSIST] = 1'b0;
               req[LK_PASSWD]  = 1'b0;
            end
         end
      end else begin : g_free
         assign req = prog_mask;
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LOCKS; gi++) begin : g_cell
         logic pend_q;
         logic keep_q = 1'b0;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend_q <= 1'b0;
            else if (exit_go)
               pend_q <= 1'b0;
            else if (prog_go && req[gi] && !keep_q)
               pend_q <= 1'b1;
         end

         always_ff @(posedge clk) begin
            if (exit_go && pend_q)
               keep_q <= 1'b1;
         end

         assign stored[gi] = keep_q;
      end
   endgenerate
endmodule

// File: rtl/lockreg_resp.sv
module lockreg_resp
   import lockreg_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_fwd,
   input  logic                 rd_block,
   input  logic                 acc_block,
   input  logic                 lread_go,
   input  logic [DATA_W-1:0]    arr_rdata,
   input  logic [NUM_LOCKS-1:0] stored,
   output logic                 rsp_valid,
   output logic [DATA_W-1:0]    rsp_data,
   output logic                 err_pulse
);
   logic [DATA_W-1:0] lock_word;

   generate
      if (DATA_W == NUM_LOCKS) begin : g_exact
         assign lock_word = stored;
      end else begin : g_pad
         assign lock_word = {{(DATA_W-NUM_LOCKS){1'b1}}, stored};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         err_pulse <= 1'b0;
      end else begin
         rsp_valid <= rd_fwd || rd_block || lread_go;
         err_pulse <= acc_block;
         if (lread_go)
            rsp_data <= lock_word;
         else if (rd_block)
            rsp_data <= '1;
         else if (rd_fwd)
            rsp_data <= arr_rdata;
      end
   end
endmodule

// File: rtl/lockreg_ctrl.sv
module lockreg_ctrl
   import lockreg_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned GUARD_BANK = 0,
   parameter bit EXCLUSIVE_MODES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              arr_en,
   output logic              arr_we,
   output logic [BANK_W-1:0] arr_bank,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              err_pulse,
   output logic              mode_busy,
   output logic [2:0]        lock_bits
);
   localparam int unsigned NUM_BANKS = 1 << BANK_W;

   generate
      if (DATA_W < NUM_LOCKS) begin : g_bad_data
         $error("DATA_W must hold all lock flags");
      end
      if (GUARD_BANK >= NUM_BANKS) begin : g_bad_guard
         $error("GUARD_BANK outside bank range");
      end
      if (BANK_W < 1 || ADDR_W < 1) begin : g_bad_addr
         $error("address fields must be non-empty");
      end
   endgenerate

   logic mode_q;
   logic acc_fwd, acc_wr, rd_fwd, acc_block, rd_block;
   logic enter_go, prog_go, lread_go, exit_go;
   logic [NUM_LOCKS-1:0] stored;

   lockreg_decode #(.BANK_W(BANK_W), .GUARD_BANK(GUARD_BANK)) u_dec (
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
      .mode_q(mode_q), .acc_fwd(acc_fwd), .acc_wr(acc_wr),
      .rd_fwd(rd_fwd), .acc_block(acc_block), .rd_block(rd_block),
      .enter_go(enter_go), .prog_go(prog_go), .lread_go(lread_go),
      .exit_go(exit_go)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= 1'b0;
      else if (enter_go)
         mode_q <= 1'b1;
      else if (exit_go)
         mode_q <= 1'b0;
   end

   lockreg_otp #(.EXCLUSIVE_MODES(EXCLUSIVE_MODES)) u_otp (
      .clk(clk), .rst_n(rst_n), .prog_go(prog_go),
      .prog_mask(cmd_wdata[NUM_LOCKS-1:0]), .exit_go(exit_go),
      .stored(stored)
   );

   lockreg_resp #(.DATA_W(DATA_W)) u_rsp (
      .clk(clk), .rst_n(rst_n), .rd_fwd(rd_fwd), .rd_block(rd_block),
      .acc_block(acc_block), .lread_go(lread_go), .arr_rdata(arr_rdata),
      .stored(stored), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .err_pulse(err_pulse)
   );

   assign arr_en    = acc_fwd;
   assign arr_we    = acc_fwd && acc_wr;
   assign arr_bank  = cmd_bank;
   assign arr_addr  = cmd_addr;
   assign arr_wdata = cmd_wdata;
   assign mode_busy = mode_q;
   assign lock_bits = stored;
endmodule

// File: rtl/lockreg_ctrl_chk.sv
module lockreg_ctrl_chk #(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned GUARD_BANK = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic [BANK_W-1:0] cmd_bank,
   input logic              arr_en,
   input logic              rsp_valid,
   input logic              err_pulse,
   input logic              mode_busy,
   input logic [2:0]        lock_bits
);
   logic guarded_rw;
   logic exit_seen;
   assign guarded_rw = cmd_valid && mode_busy && (cmd_bank == BANK_W'(GUARD_BANK))
                       && (cmd_op == 3'd1 || cmd_op == 3'd2);
   assign exit_seen  = cmd_valid && mode_busy && (cmd_op == 3'd6);

   assert_guard_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      guarded_rw |-> !arr_en);

   assert_guard_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      guarded_rw |=> err_pulse);

   assert_lock_no_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(lock_bits) & ~lock_bits) == 3'b000));

   assert_commit_on_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lock_bits) |-> $past(exit_seen));

   assert_lread_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !mode_busy && cmd_op == 3'd5) |=> !rsp_valid);
endmodule

bind lockreg_ctrl lockreg_ctrl_chk #(.BANK_W(BANK_W), .GUARD_BANK(GUARD_BANK)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_bank(cmd_bank), .arr_en(arr_en), .rsp_valid(rsp_valid),
   .err_pulse(err_pulse), .mode_busy(mode_busy), .lock_bits(lock_bits)
);

// File: tb/sim_lockreg_ctrl.sv
`timescale 1ns/1ps
module sim_lockreg_ctrl;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [1:0] cmd_bank = 2'd0;
   logic [5:0] cmd_addr = 6'd0;
   logic [7:0] cmd_wdata = 8'd0;
   logic arr_en, arr_we;
   logic [1:0] arr_bank;
   logic [5:0] arr_addr;
   logic [7:0] arr_wdata, arr_rdata;
   logic rsp_valid, err_pulse, mode_busy;
   logic [7:0] rsp_data;
   logic [2:0] lock_bits;

   int tests = 0;
   int fails = 0;
   logic last_en;
   logic [2:0] exp_lock = 3'b000;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign arr_rdata = {arr_bank, arr_addr} ^ 8'h5A;

   lockreg_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .arr_en(arr_en), .arr_we(arr_we), .arr_bank(arr_bank),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err_pulse(err_pulse),
      .mode_busy(mode_busy), .lock_bits(lock_bits)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive at a falling edge, hold across one rising edge, release at the next falling edge
   task automatic issue(input logic [2:0] op, input logic [1:0] b,
                        input logic [5:0] a, input logic [7:0] w);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_bank = b; cmd_addr = a; cmd_wdata = w;
      #1 last_en = arr_en;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      do_reset();
      check("R10 reset mode", mode_busy, 0);
      check("R10 reset lock", lock_bits, 0);
      check("R3 reset err", err_pulse, 0);
      check("R1 reset rsp", rsp_valid, 0);

      // R1: lock commands outside lock mode
      for (int op = 4; op <= 6; op++) begin
         issue(3'(op), 2'd1, 6'd0, 8'h07);
         check("R1 no rsp", rsp_valid, 0);
         check("R1 no err", err_pulse, 0);
         check("R1 mode stays", mode_busy, 0);
         check("R1 lock stays", lock_bits, 0);
      end

      // R4/R5: every bank forwarded outside lock mode
      for (int b = 0; b < 4; b++) begin
         issue(3'd1, 2'(b), 6'(b*9+3), 8'h00);
         check("R5 fwd outside", last_en, 1);
         check("R4 rsp data", rsp_data, ({2'(b), 6'(b*9+3)} ^ 8'h5A));
         check("R4 rsp valid", rsp_valid, 1);
      end

      issue(3'd3, 2'd0, 6'd0, 8'h00);
      check("R2 enter", mode_busy, 1);
      issue(3'd3, 2'd0, 6'd0, 8'h00);
      check("R2 re-enter holds", mode_busy, 1);

      // R3/R4 sweep of banks and access kinds inside lock mode
      for (int b = 0; b < 4; b++) begin
         for (int k = 1; k <= 2; k++) begin
            issue(3'(k), 2'(b), 6'(b+k*5), 8'hC3);
            if (b == 0) begin
               check("R3 not forwarded", last_en, 0);
               check("R3 err pulse", err_pulse, 1);
               if (k == 1) check("R3 ones", rsp_data, 8'hFF);
               @(negedge clk);
               check("R3 err one cycle", err_pulse, 0);
            end else begin
               check("R4 forwarded", last_en, 1);
               check("R4 no err", err_pulse, 0);
               if (k == 1) check("R4 data", rsp_data, ({2'(b), 6'(b+k*5)} ^ 8'h5A));
            end
            check("R2 busy held", mode_busy, 1);
         end
      end

      issue(3'd5, 2'd0, 6'd0, 8'h00);
      check("R9 lread valid", rsp_valid, 1);
      check("R9 lread data", rsp_data, 8'hF8);

      issue(3'd4, 2'd0, 6'd0, 8'h01);
      check("R6 not yet", lock_bits, 0);
      issue(3'd5, 2'd0, 6'd0, 8'h00);
      check("R6 read unchanged", rsp_data, 8'hF8);

      // R10: reset drops the pending secure bit and the mode
      do_reset();
      check("R10 mode cleared", mode_busy, 0);
      issue(3'd3, 2'd0, 6'd0, 8'h00);
      issue(3'd6, 2'd0, 6'd0, 8'h00);
      check("R10 pending dropped", lock_bits, 0);
      check("R5 exit", mode_busy, 0);
      issue(3'd2, 2'd0, 6'd4, 8'h11);
      check("R5 bank0 write again", last_en, 1);
      check("R5 no err", err_pulse, 0);

      // R7: both mode selections in one program
      issue(3'd3, 2'd0, 6'd0, 8'h00);
      issue(3'd4, 2'd0, 6'd0, 8'h06);
      issue(3'd6, 2'd0, 6'd0, 8'h00);
      check("R7 both dropped", lock_bits, 0);

      // R6/R7/R8 sweep of every mask with an arithmetic model
      for (int w = 0; w < 8; w++) begin
         logic [2:0] req;
         req = 3'(w);
         if (req[1] && req[2]) req[2:1] = 2'b00;
         issue(3'd3, 2'd0, 6'd0, 8'h00);
         issue(3'd4, 2'd0, 6'd0, 8'(w));
         check("R6 held before exit", lock_bits, exp_lock);
         issue(3'd6, 2'd0, 6'd0, 8'h00);
         exp_lock = exp_lock | req;
         check("R8 R7 committed", lock_bits, exp_lock);
         if (w == 3) begin
            do_reset();
            check("R10 lock kept", lock_bits, exp_lock);
            issue(3'd3, 2'd0, 6'd0, 8'h00);
            issue(3'd5, 2'd0, 6'd0, 8'h00);
            check("R9 lread after reset", rsp_data, {5'b11111, exp_lock});
            issue(3'd6, 2'd0, 6'd0, 8'h00);
         end
      end

      issue(3'd3, 2'd0, 6'd0, 8'h00);
      issue(3'd4, 2'd0, 6'd0, 8'h00);
      issue(3'd6, 2'd0, 6'd0, 8'h00);
      check("R8 never cleared", lock_bits, exp_lock);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule